// File: doc/BRIEF.md
# External Edge-Interrupt Line Controller

The controller watches a parameterised set of external interrupt lines (23 by default). It brings each line into the clock domain through a two-flop synchroniser and then detects edges on it. Each line has its own choice of rising, falling or both edges as a trigger. A trigger latches a per-line pending flag. The flags, gated by an interrupt mask, are ORed into one interrupt request. A second, independent mask turns triggers into single-cycle event pulses.

Software reaches six word-indexed 32-bit registers over a simple bus: word index, write strobe, write data and combinational read data. Software can set pending flags directly through a trigger register, and clears them by writing ones.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and `evt_o` is low.
- R2: Word indices 0, 1, 2 and 3 are the interrupt mask, event mask, rising select and falling select. They read back what was written. Bit n controls line n, and bits at or above NUM_LINES read zero.
- R3: `irq_o` is high exactly when some line has both its pending bit and its interrupt-mask bit set.
- R4: A trigger on a line whose event-mask bit is set gives a one-cycle `evt_o` pulse in the same cycle that its pending bit first reads one. This does not depend on the interrupt mask.
- R5: With the rising-select bit set, a low-to-high change of a line sampled at clock edge E0 makes its pending bit read one after edge E2 and not before.
- R6: With only the falling-select bit set, a high-to-low change sets pending, and a low-to-high change does not.
- R7: With both select bits set, either edge sets pending.
- R8: With neither select bit set, no change on a line sets its pending bit.
- R9: Writing a one to bit n of word index 4 (software trigger) sets pending bit n at that write's edge and fires the event pulse if unmasked. Index 4 always reads zero.
- R10: Writing a one to bit n of word index 5 (pending) clears that bit. Writing zero leaves it unchanged.
- R11: If a hardware trigger and a write-one clear hit the same pending bit on the same edge, the bit stays set.
- R12: Word indices 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lines_i | input | NUM_LINES | Asynchronous external interrupt lines |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Combined masked interrupt request |
| evt_o | output | 1 | Single-cycle event pulse |

## Verification
The hardest case to reach from the ports is R11, where a synchronised hardware edge and a write-one clear land on the same pending bit at the same clock edge. The bench first sets the pending bit. It then toggles the line at a known falling clock edge and counts the two synchroniser stages. It asserts the clear write so that the strobe is live exactly at the edge where the trigger arrives. The edge-select matrix is covered by a table that walks every select setting against both directions of change.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_IMASK  = 3'd0,
    REG_EMASK  = 3'd1,
    REG_RISE   = 3'd2,
    REG_FALL   = 3'd3,
    REG_SWTRIG = 3'd4,
    REG_PEND   = 3'd5,
    REG_RSV6   = 3'd6,
    REG_RSV7   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int N      = 23,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
  parameter int N = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  output logic [N-1:0] trig_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic up, dn;
    assign up        = sync_i[i] & ~prev_q[i];
    assign dn        = ~sync_i[i] & prev_q[i];
    assign trig_o[i] = (up & rise_en_i[i]) | (dn & fall_en_i[i]);
  end

  // a trigger needs a level change since the previous cycle (R5, R6, R7)
  p_trig_needs_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trig_o) |-> (sync_i != $past(sync_i)));
  // no trigger on a line with neither select bit (R8)
  p_trig_unselected_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((trig_o & ~(rise_en_i | fall_en_i)) == '0));
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int N = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      hw_trig_i,
  output logic [N-1:0]      imask_o,
  output logic [N-1:0]      rise_o,
  output logic [N-1:0]      fall_o,
  output logic [N-1:0]      pend_o,
  output logic [N-1:0]      rd_o,
  output logic              evt_o
);
  logic [N-1:0] imask_q, emask_q, rise_q, fall_q, pend_q;
  logic [N-1:0] wd, sw_set, clr, trig_all;
  logic         evt_q;

  assign wd       = wdata_i[N-1:0];
  assign sw_set   = (we_i && sel_i == REG_SWTRIG) ? wd : '0;
  assign clr      = (we_i && sel_i == REG_PEND)   ? wd : '0;
  assign trig_all = hw_trig_i | sw_set;

  if (N < DATA_W) begin : g_unused
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:N];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      pend_q  <= '0;
      evt_q   <= 1'b0;
    end else begin
      if (we_i) begin
        case (sel_i)
          REG_IMASK: imask_q <= wd;
          REG_EMASK: emask_q <= wd;
          REG_RISE:  rise_q  <= wd;
          REG_FALL:  fall_q  <= wd;
          default:   ;
        endcase
      end
      // set beats clear
      pend_q <= (pend_q & ~clr) | trig_all;
      evt_q  <= |(trig_all & emask_q);
    end
  end

  always_comb begin
    case (sel_i)
      REG_IMASK: rd_o = imask_q;
      REG_EMASK: rd_o = emask_q;
      REG_RISE:  rd_o = rise_q;
      REG_FALL:  rd_o = fall_q;
      REG_PEND:  rd_o = pend_q;
      default:   rd_o = '0;
    endcase
  end

  assign imask_o = imask_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign pend_o  = pend_q;
  assign evt_o   = evt_q;

  p_pend_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_trig_i) |=> ((pend_q & $past(hw_trig_i)) == $past(hw_trig_i)));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == REG_PEND && |(wd & ~hw_trig_i))
      |=> ((pend_q & $past(wd & ~hw_trig_i)) == '0));
  p_race_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == REG_PEND && |(wd & hw_trig_i))
      |=> ((pend_q & $past(wd & hw_trig_i)) == $past(wd & hw_trig_i)));
  p_evt_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(|emask_q));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES   = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o,
  output logic                 evt_o
);
  localparam int N = NUM_LINES;

  reg_sel_e     sel;
  logic [N-1:0] sync, trig, imask, rise, fall, pend, rd;

  assign sel = reg_sel_e'(addr_i);

  ext_irq_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (lines_i),
    .sync_o  (sync)
  );

  ext_irq_edge #(.N(N)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync),
    .rise_en_i (rise),
    .fall_en_i (fall),
    .trig_o    (trig)
  );

  ext_irq_regs #(.N(N)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .sel_i     (sel),
    .wdata_i   (wdata_i),
    .hw_trig_i (trig),
    .imask_o   (imask),
    .rise_o    (rise),
    .fall_o    (fall),
    .pend_o    (pend),
    .rd_o      (rd),
    .evt_o     (evt_o)
  );

  assign irq_o = |(pend & imask);

  if (N < DATA_W) begin : g_pad
    assign rdata_o = {{(DATA_W-N){1'b0}}, rd};
    p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[DATA_W-1:N] == '0);
  end else begin : g_full
    assign rdata_o = rd;
  end

  p_swtrig_rd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_SWTRIG) |-> (rdata_o == '0));
  p_irq_needs_pend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (|pend));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  import ext_irq_pkg::*;

  localparam int NL = 23;
  localparam int TL = 3;   // line used by the table
  localparam int NV = 9;
  // {rise_sel, fall_sel, level_from, level_to, expected_pending}
  localparam logic [4:0] VEC [NV] = '{
    5'b10_01_1, 5'b10_10_0, 5'b01_10_1, 5'b01_01_0, 5'b11_01_1,
    5'b11_10_1, 5'b00_01_0, 5'b00_10_0, 5'b11_11_0
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NL-1:0]     lines = '0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq, evt;
  int                n_chk = 0, n_fail = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(NL)) u_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .evt_o(evt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 irq reset", {31'h0, irq}, 32'h0);
    chk("R1 evt reset", {31'h0, evt}, 32'h0);

    // R2 readback and upper bits
    wr(REG_FALL, 32'hFFFF_FFFF);
    rd(REG_FALL, v); chk("R2 fall readback", v, 32'h007F_FFFF);
    wr(REG_FALL, 32'h0);
    wr(REG_EMASK, 32'hA5A5_A5A5);
    rd(REG_EMASK, v); chk("R2 emask readback", v, 32'h0025_A5A5);
    wr(REG_EMASK, 32'h0);

    // R12 reserved indices
    rd(3'd6, v); chk("R12 idx6", v, 32'h0);
    rd(3'd7, v); chk("R12 idx7", v, 32'h0);

    // R5 R6 R7 R8 edge-select table on line TL
    for (int i = 0; i < NV; i++) begin
      wr(REG_RISE, 32'h0); wr(REG_FALL, 32'h0);
      lines[TL] = VEC[i][2];
      cyc(4);
      wr(REG_PEND, 32'hFFFF_FFFF);
      wr(REG_RISE, VEC[i][4] ? (32'h1 << TL) : 32'h0);
      wr(REG_FALL, VEC[i][3] ? (32'h1 << TL) : 32'h0);
      lines[TL] = VEC[i][1];
      cyc(4);
      rd(REG_PEND, v);
      chk($sformatf("R5/R6/R7/R8 vec%0d", i), v, VEC[i][0] ? (32'h1 << TL) : 32'h0);
    end
    wr(REG_RISE, 32'h0); wr(REG_FALL, 32'h0);
    lines[TL] = 1'b0; cyc(4);
    wr(REG_PEND, 32'hFFFF_FFFF);

    // R5 latency, R3 irq, R4 evt on line 5
    wr(REG_RISE, 32'h20); wr(REG_IMASK, 32'h20); wr(REG_EMASK, 32'h20);
    lines[5] = 1'b1;                // sampled at E0
    @(posedge clk); @(negedge clk); // after E0
    rd(REG_PEND, v); chk("R5 not after E0", v, 32'h0);
    @(posedge clk); @(negedge clk); // after E1
    rd(REG_PEND, v); chk("R5 not after E1", v, 32'h0);
    chk("R3 irq low before pend", {31'h0, irq}, 32'h0);
    @(posedge clk); @(negedge clk); // after E2
    rd(REG_PEND, v); chk("R5 set after E2", v, 32'h20);
    chk("R4 evt pulse", {31'h0, evt}, 32'h1);
    chk("R3 irq high", {31'h0, irq}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R4 evt one cycle", {31'h0, evt}, 32'h0);
    wr(REG_IMASK, 32'h0);
    chk("R3 irq masked", {31'h0, irq}, 32'h0);

    // R10 write zero no effect
    wr(REG_PEND, 32'h0);
    rd(REG_PEND, v); chk("R10 write zero", v, 32'h20);

    // R11 clear and trigger on the same edge
    lines[5] = 1'b0; cyc(4);
    lines[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    we = 1'b1; addr = REG_PEND; wdata = 32'h20;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    rd(REG_PEND, v); chk("R11 set wins", v, 32'h20);

    // R10 plain clear
    wr(REG_PEND, 32'h20);
    rd(REG_PEND, v); chk("R10 clear", v, 32'h0);

    // R9 software trigger, R4 event without interrupt mask
    wr(REG_EMASK, 32'h80);
    we = 1'b1; addr = REG_SWTRIG; wdata = 32'h80;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    chk("R9 sw evt", {31'h0, evt}, 32'h1);
    chk("R4 irq stays low", {31'h0, irq}, 32'h0);
    rd(REG_PEND, v); chk("R9 sw pend", v, 32'h80);
    rd(REG_SWTRIG, v); chk("R9 sw reads zero", v, 32'h0);
    wr(REG_IMASK, 32'h80);
    chk("R3 irq from sw pend", {31'h0, irq}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule